// File: doc/BRIEF.md
# Incremental Phase Shift Controller

This controller serves a fine phase-adjust interface clocked by its own phase-shift clock. A request is a single-cycle enable pulse that carries a direction bit, and each request asks for one phase step. The controller does not jump to the new phase. It walks an internal phase accumulator toward the target one sub-step per clock, with no reversal on the way. When the target is reached it raises a one-cycle done pulse. The accumulator counts modulo one full period, so any number of steps in either direction wraps around and never overflows.

When no request arrives, done keeps pulsing once every 32 clocks, which gives the requester a regular cue that it may issue a request. The step number within the period and the number of steps per period are both driven as outputs, so a following tap-select or digital delay stage can map the phase onto its own taps. A request that arrives while a shift is still running has no effect on the phase. It is recorded in a saturating error counter.

Top module: `phase_step_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after its release, phase_fine_o, phase_step_o, err_cnt_o, busy_o and done_o are all zero.
- R2: psen_i high while busy_o is low starts a shift. busy_o is high in the next cycle, and phase_fine_o does not change on that accepting edge.
- R3: With incdec_i=1 captured, phase_fine_o rises by exactly one sub-step on each of the next SUB_STEPS edges, and it never changes direction within a shift.
- R4: With incdec_i=0 captured, phase_fine_o falls by exactly one sub-step on each of the next SUB_STEPS edges. A decrement from 0 gives STEPS_PER_PERIOD*SUB_STEPS-1.
- R5: phase_fine_o always stays below STEPS_PER_PERIOD*SUB_STEPS and wraps modulo that value. STEPS_PER_PERIOD increments starting from 0 return it to 0.
- R6: done_o is high for exactly one cycle. That cycle is the first in which the final phase value appears and busy_o is low. After it a new request is accepted, including one in the done cycle itself.
- R7: While no shift is running, done_o pulses every 32 cycles. The first pulse comes 32 cycles after reset release, or 32 cycles after the previous done pulse.
- R8: psen_i high while busy_o is high does not change the phase trajectory, the shift length or done timing, and it adds one to err_cnt_o.
- R9: err_cnt_o saturates at its all-ones value and never decreases except on reset.
- R10: steps_per_period_o equals STEPS_PER_PERIOD at all times, and phase_step_o equals phase_fine_o divided by SUB_STEPS, rounded down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase-shift clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psen_i | input | 1 | One-cycle shift request |
| incdec_i | input | 1 | Direction: 1 increment, 0 decrement |
| done_o | output | 1 | One-cycle completion / idle-ready pulse |
| busy_o | output | 1 | Shift in progress |
| phase_fine_o | output | $clog2(STEPS_PER_PERIOD*SUB_STEPS) | Phase accumulator in sub-steps |
| phase_step_o | output | $clog2(STEPS_PER_PERIOD) | Current step index within the period |
| steps_per_period_o | output | $clog2(STEPS_PER_PERIOD+1) | Constant steps-per-period value |
| err_cnt_o | output | ERR_W | Saturating count of ignored requests |

## Verification
The bench builds the controller with STEPS_PER_PERIOD=6, SUB_STEPS=3 and ERR_W=2. This gives an 18-sub-step period that is not a power of two, so the explicit wrap logic is exercised instead of natural binary rollover. A full period takes only six shifts, and a single decrement from zero crosses the wrap point. With two error bits, three stray requests are enough to reach saturation, and a fourth shows that the count holds there. A three-cycle ramp is also long enough for a stray request to land in the middle of a shift.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic {
    DIR_DEC = 1'b0,
    DIR_INC = 1'b1
  } dir_e;
endpackage

// File: rtl/psc_sequencer.sv
module psc_sequencer
  import psc_pkg::*;
#(
  parameter int SUB_STEPS   = 8,
  parameter int IDLE_PERIOD = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic psen_i,
  input  logic incdec_i,
  output logic move_o,
  output dir_e dir_o,
  output logic busy_o,
  output logic done_o,
  output logic stray_o
);
  localparam int REM_W  = $clog2(SUB_STEPS + 1);
  localparam int IDLE_W = (IDLE_PERIOD > 1) ? $clog2(IDLE_PERIOD) : 1;

  logic              busy_q, done_q;
  logic [REM_W-1:0]  rem_q;
  logic [IDLE_W-1:0] idle_q;
  dir_e              dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
      idle_q <= '0;
      dir_q  <= DIR_DEC;
    end else if (busy_q) begin
      rem_q <= rem_q - 1'b1;
      if (rem_q == REM_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        idle_q <= '0;
      end else begin
        done_q <= 1'b0;
      end
    end else if (psen_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      rem_q  <= REM_W'(SUB_STEPS);
      idle_q <= '0;
      dir_q  <= dir_e'(incdec_i);
    end else if (idle_q == IDLE_W'(IDLE_PERIOD - 1)) begin
      done_q <= 1'b1;
      idle_q <= '0;
    end else begin
      done_q <= 1'b0;
      idle_q <= idle_q + 1'b1;
    end
  end

  // accumulator moves on every edge while a shift is open
  assign move_o  = busy_q;
  assign dir_o   = dir_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign stray_o = busy_q & psen_i;
endmodule

// File: rtl/psc_phase_acc.sv
module psc_phase_acc
  import psc_pkg::*;
#(
  parameter int TOTAL = 448,
  parameter int SUB   = 8,
  parameter int ACC_W = 9,
  parameter int STEP_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              move_i,
  input  dir_e              dir_i,
  output logic [ACC_W-1:0]  phase_o,
  output logic [STEP_W-1:0] step_o
);
  localparam bit              POW2 = (TOTAL & (TOTAL - 1)) == 0 && (1 << ACC_W) == TOTAL;
  localparam logic [ACC_W-1:0] LAST = ACC_W'(TOTAL - 1);

  logic [ACC_W-1:0] acc_q, acc_d, step_full;

  generate
    if (POW2) begin : g_natural_wrap
      always_comb acc_d = (dir_i == DIR_INC) ? acc_q + 1'b1 : acc_q - 1'b1;
    end else begin : g_cmp_wrap
      always_comb begin
        if (dir_i == DIR_INC) acc_d = (acc_q == LAST) ? '0 : acc_q + 1'b1;
        else                  acc_d = (acc_q == '0) ? LAST : acc_q - 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (move_i) acc_q <= acc_d;
  end

  assign step_full = acc_q / ACC_W'(SUB);
  assign phase_o   = acc_q;
  assign step_o    = step_full[STEP_W-1:0];
endmodule

// File: rtl/psc_err_cnt.sv
module psc_err_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hit_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (hit_i && cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
  import psc_pkg::*;
#(
  parameter int STEPS_PER_PERIOD = 56,
  parameter int SUB_STEPS        = 8,
  parameter int ERR_W            = 8,
  parameter int IDLE_PERIOD      = 32,
  localparam int TOTAL_SUB = STEPS_PER_PERIOD * SUB_STEPS,
  localparam int ACC_W     = (TOTAL_SUB > 1) ? $clog2(TOTAL_SUB) : 1,
  localparam int STEP_W    = (STEPS_PER_PERIOD > 1) ? $clog2(STEPS_PER_PERIOD) : 1,
  localparam int SPP_W     = $clog2(STEPS_PER_PERIOD + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psen_i,
  input  logic              incdec_i,
  output logic              done_o,
  output logic              busy_o,
  output logic [ACC_W-1:0]  phase_fine_o,
  output logic [STEP_W-1:0] phase_step_o,
  output logic [SPP_W-1:0]  steps_per_period_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  logic move;
  logic stray;
  dir_e dir;

  psc_sequencer #(
    .SUB_STEPS  (SUB_STEPS),
    .IDLE_PERIOD(IDLE_PERIOD)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .psen_i  (psen_i),
    .incdec_i(incdec_i),
    .move_o  (move),
    .dir_o   (dir),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .stray_o (stray)
  );

  psc_phase_acc #(
    .TOTAL (TOTAL_SUB),
    .SUB   (SUB_STEPS),
    .ACC_W (ACC_W),
    .STEP_W(STEP_W)
  ) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .move_i (move),
    .dir_i  (dir),
    .phase_o(phase_fine_o),
    .step_o (phase_step_o)
  );

  psc_err_cnt #(
    .W(ERR_W)
  ) u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (stray),
    .cnt_o (err_cnt_o)
  );

  assign steps_per_period_o = SPP_W'(STEPS_PER_PERIOD);
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
  parameter int TOTAL = 448,
  parameter int ACC_W = 9,
  parameter int ERR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             psen_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [ACC_W-1:0] phase_fine_o,
  input logic [ERR_W-1:0] err_cnt_o
);
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(phase_fine_o)); // R2

  AST_ONE_SUBSTEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (int'(phase_fine_o) == (int'($past(phase_fine_o)) + 1) % TOTAL) ||
               (int'(phase_fine_o) == (int'($past(phase_fine_o)) + TOTAL - 1) % TOTAL)); // R3

  AST_NO_REVERSAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) &&
     int'(phase_fine_o) == (int'($past(phase_fine_o)) + 1) % TOTAL)
    |=> int'(phase_fine_o) == (int'($past(phase_fine_o)) + 1) % TOTAL); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(phase_fine_o) < TOTAL); // R5

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R6

  AST_STRAY_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && psen_i && err_cnt_o != '1) |=> err_cnt_o == $past(err_cnt_o) + 1'b1); // R8

  AST_ERR_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o == '1) |=> (err_cnt_o == '1)); // R9
endmodule

bind phase_step_ctrl psc_checker #(
  .TOTAL(TOTAL_SUB),
  .ACC_W(ACC_W),
  .ERR_W(ERR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .psen_i      (psen_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .phase_fine_o(phase_fine_o),
  .err_cnt_o   (err_cnt_o)
);

// File: tb/tb_phase_step_ctrl.sv
module tb_phase_step_ctrl;
  localparam int STEPS = 6;
  localparam int SUB   = 3;
  localparam int ERRW  = 2;
  localparam int TOT   = STEPS * SUB;
  localparam int ERRMAX = (1 << ERRW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psen = 1'b0;
  logic incdec = 1'b0;
  logic done, busy;
  logic [$clog2(TOT)-1:0]     ph_fine;
  logic [$clog2(STEPS)-1:0]   ph_step;
  logic [$clog2(STEPS+1)-1:0] spp;
  logic [ERRW-1:0]            err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  phase_step_ctrl #(
    .STEPS_PER_PERIOD(STEPS),
    .SUB_STEPS       (SUB),
    .ERR_W           (ERRW)
  ) dut (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .psen_i            (psen),
    .incdec_i          (incdec),
    .done_o            (done),
    .busy_o            (busy),
    .phase_fine_o      (ph_fine),
    .phase_step_o      (ph_step),
    .steps_per_period_o(spp),
    .err_cnt_o         (err)
  );

  always #5 clk = ~clk;

  // behavioural reference: queue of pending sub-step moves
  int m_q[$];
  int m_ph = 0, m_err = 0, m_idle = 0;
  bit m_done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete();
      m_ph = 0; m_err = 0; m_idle = 0; m_done = 0;
    end else if (m_q.size() > 0) begin
      int d;
      if (psen && m_err < ERRMAX) m_err++;
      d = m_q.pop_front();
      m_ph = (m_ph + d + TOT) % TOT;
      if (m_q.size() == 0) begin m_done = 1; m_idle = 0; end
      else m_done = 0;
    end else if (psen) begin
      for (int i = 0; i < SUB; i++) m_q.push_back(incdec ? 1 : -1);
      m_done = 0; m_idle = 0;
    end else if (m_idle == 31) begin
      m_done = 1; m_idle = 0;
    end else begin
      m_done = 0; m_idle++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("R3/R4 phase_fine", int'(ph_fine), m_ph);
      chk("R10 phase_step", int'(ph_step), m_ph / SUB);
      chk("R10 steps_per_period", int'(spp), STEPS);
      chk("R2 busy", int'(busy), int'(m_q.size() > 0));
      chk("R6/R7 done", int'(done), int'(m_done));
      chk("R8/R9 err_cnt", int'(err), m_err);
    end
  end

  task automatic shift(bit dir, bit stray);
    @(negedge clk);
    psen = 1'b1; incdec = dir;
    @(negedge clk);
    psen = stray;
    incdec = ~dir; // must not matter once captured
    @(negedge clk);
    psen = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    int dones;
    repeat (3) @(negedge clk);
    chk("R1 reset phase", int'(ph_fine), 0);
    chk("R1 reset busy/done", int'(busy | done), 0);
    chk("R1 reset err", int'(err), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release phase", int'(ph_fine), 0);

    // R7: idle pulses
    dones = 0;
    repeat (64) begin @(negedge clk); if (done) dones++; end
    chk("R7 idle done count in 64", dones, 2);

    // R3 increment
    shift(1'b1, 1'b0);
    chk("R6 done at final value", int'(done), 1);
    chk("R3 after inc", int'(ph_fine), SUB);

    // R5 wrap after full period of increments
    for (int k = 0; k < STEPS - 1; k++) shift(1'b1, 1'b0);
    chk("R5 full period wrap", int'(ph_fine), 0);

    // R4 decrement across zero
    @(negedge clk);
    psen = 1'b1; incdec = 1'b0;
    @(negedge clk);
    psen = 1'b0;
    chk("R2 busy after accept", int'(busy), 1);
    chk("R2 phase held on accept", int'(ph_fine), 0);
    while (busy) @(negedge clk);
    chk("R4 decrement wraps", int'(ph_fine), TOT - SUB);

    // R6 back-to-back: accept in done cycle
    psen = 1'b1; incdec = 1'b1;
    @(negedge clk);
    psen = 1'b0;
    chk("R6 accepted in done cycle", int'(busy), 1);
    while (busy) @(negedge clk);
    chk("R6 back-to-back result", int'(ph_fine), 0);

    // R8 stray request mid-shift
    shift(1'b1, 1'b1);
    chk("R8 stray ignored phase", int'(ph_fine), SUB);
    chk("R8 stray counted", int'(err), 1);

    // R9 saturation
    for (int k = 0; k < 3; k++) shift(1'b0, 1'b1);
    chk("R9 saturated", int'(err), ERRMAX);
    chk("R8 phase after strays", int'(ph_fine), (SUB - 3 * SUB + 3 * TOT) % TOT);

    // R7 idle cadence after a shift
    dones = 0;
    repeat (32) begin @(negedge clk); if (done) dones++; end
    chk("R7 one done 32 after shift", dones, 1);
    chk("R7 pulse lands on 32nd", int'(done), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule